// File: doc/BRIEF.md
# SIMD/FP Shared Register State Tracker

This block keeps the architectural state of a register file that packed-integer SIMD instructions share with the floating-point unit: eight 64-bit data registers that alias the floating-point stack, and a 16-bit tag word holding one 2-bit field per register. The decoder presents one instruction per cycle on a strobe. The strobe carries the instruction class, the second opcode byte, two register operand indices, a flag that marks the second operand as memory, the 32-bit and 64-bit source values, the lock-prefix flag, the control bits EM, TS and NE, and a pending floating-point exception flag.

For each strobe the block decides between a fault and a commit. A committed SIMD instruction marks every tag field valid. A committed empty-state instruction marks every field empty. The four move forms read or write the register file, and a read result comes out on a data port. A faulting instruction changes nothing. Address generation, memory faults and floating-point arithmetic belong to neighbouring blocks.

Class encoding on `instClass`: 0 = other, 1 = SIMD, 2 = empty-state, 3 = floating-point. All outputs are registered. They reflect a strobe from the cycle after it was presented, and the register file and `tagWord` are updated at that same edge.

Top module: `simd_fp_state_tracker`

## Requirements
- R1: A synchronous reset clears all eight data registers to zero, sets `tagWord` to 16'hFFFF, and holds `commit`, `faultValid`, `ferr` and `dataOutValid` low.
- R2: A committed SIMD-class instruction (class 1) of any opcode sets `tagWord` to 16'h0000.
- R3: A committed empty-state instruction (class 2) sets `tagWord` to 16'hFFFF and touches no data register.
- R4: A class 1 or class 2 instruction that arrives with EM set or with the lock prefix raises `faultVector` 6. This takes priority over every other condition.
- R5: With no R4 condition, a class 1, 2 or 3 instruction that arrives with TS set raises `faultVector` 7.
- R6: With no R4 or R5 condition, a class 1 or 2 instruction that arrives with a pending FP exception asserts `ferr` and does not commit. It raises `faultVector` 16 only when NE is set; with NE clear it reports neither a fault nor a commit.
- R7: SIMD opcode 8'h6E writes `gprIn` into bits 31:0 of register `regA` and clears bits 63:32.
- R8: SIMD opcode 8'h7E returns bits 31:0 of register `regA` on `dataOut`, zero-extended, with `dataOutValid` high.
- R9: SIMD opcode 8'h6F writes register `regA` from `memIn` when `bIsMem` is 1, and from register `regB` otherwise.
- R10: SIMD opcode 8'h7F returns register `regA` on `dataOut` when `bIsMem` is 1. Otherwise it copies register `regA` into register `regB`.
- R11: A class 0 instruction, or a class 3 instruction without TS, commits and leaves the tag word and all data registers unchanged.
- R12: Outputs appear one cycle after the strobe. `commit` and `faultValid` are never high together, and without a strobe both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Decoded-instruction strobe |
| instClass | input | 2 | Instruction class: 0 other, 1 SIMD, 2 empty-state, 3 FP |
| opByte | input | 8 | Opcode byte that follows the 0F escape |
| lockPfx | input | 1 | Lock prefix present |
| ctlEm | input | 1 | Control bit: SIMD emulation |
| ctlTs | input | 1 | Control bit: task switched |
| ctlNe | input | 1 | Control bit: native FP error reporting |
| fpExcPend | input | 1 | Floating-point exception pending |
| regA | input | 3 | Register operand index |
| regB | input | 3 | Register-or-memory operand index |
| bIsMem | input | 1 | Second operand is memory |
| gprIn | input | 32 | 32-bit source from an integer register or memory |
| memIn | input | 64 | 64-bit source from memory |
| commit | output | 1 | Instruction committed |
| faultValid | output | 1 | Fault reported |
| faultVector | output | 8 | Fault vector number (6, 7 or 16) |
| ferr | output | 1 | FP error signal for a pending exception |
| tagWord | output | 16 | Current tag word |
| dataOut | output | 64 | Store or read result |
| dataOutValid | output | 1 | dataOut carries a result |

## Verification
Every combination of class and the five control inputs (lock, EM, TS, NE, pending exception) is applied with a rotating opcode. This exposes any priority error between vectors 6, 7 and 16, and any commit leaking through a trap or a stall with NE clear. Periodic 64-bit readbacks of all eight registers show whether a faulting or non-SIMD instruction disturbed the file. The 32-bit forms run with values whose upper half is non-zero, which separates zero-extension from pass-through. The 64-bit forms run against both a memory source and a register source, which separates the two operand paths.

// File: rtl/simd_fp_pkg.sv
package simd_fp_pkg;
  parameter int NUM_REGS = 8;
  parameter int REG_W = 64;
  parameter int TAG_FW = 2;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int HALF_W = REG_W / 2;
  localparam int TAG_W = NUM_REGS * TAG_FW;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_SIMD  = 2'd1,
    CLS_EMPTY = 2'd2,
    CLS_FP    = 2'd3
  } instClass_e;

  localparam logic [7:0] OP_LD32 = 8'h6E;
  localparam logic [7:0] OP_ST32 = 8'h7E;
  localparam logic [7:0] OP_LD64 = 8'h6F;
  localparam logic [7:0] OP_ST64 = 8'h7F;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_NM = 8'd7;
  localparam logic [7:0] VEC_MF = 8'd16;

  typedef enum logic [1:0] {
    SRC_GPR32 = 2'd0,
    SRC_MEM64 = 2'd1,
    SRC_REG   = 2'd2
  } wrSrc_e;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    wrSrc_e           wrSrc;
    logic [IDX_W-1:0] rdIdx;
    logic             rdEn;
    logic             rdLow;
    logic             tagAllValid;
    logic             tagAllEmpty;
  } dpStrobe_t;
endpackage

// File: rtl/simd_fp_ctrl.sv
module simd_fp_ctrl
  import simd_fp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [1:0]       instClass,
  input  logic [7:0]       opByte,
  input  logic             lockPfx,
  input  logic             ctlEm,
  input  logic             ctlTs,
  input  logic             ctlNe,
  input  logic             fpExcPend,
  input  logic [IDX_W-1:0] regA,
  input  logic [IDX_W-1:0] regB,
  input  logic             bIsMem,
  output dpStrobe_t        strobe,
  output logic             commit,
  output logic             faultValid,
  output logic [7:0]       faultVector,
  output logic             ferr
);
  instClass_e cls;
  logic isSimd, isEmpty, isFp, simdLike;
  logic trapUd, trapNm, stall, trapMf, doCommit;

  always_comb begin
    cls      = instClass_e'(instClass);
    isSimd   = (cls == CLS_SIMD);
    isEmpty  = (cls == CLS_EMPTY);
    isFp     = (cls == CLS_FP);
    simdLike = isSimd | isEmpty;
    // priority: emulation/lock, then task switch, then pending FP error
    trapUd   = instValid & simdLike & (ctlEm | lockPfx);
    trapNm   = instValid & ~trapUd & (simdLike | isFp) & ctlTs;
    stall    = instValid & ~trapUd & ~trapNm & simdLike & fpExcPend;
    trapMf   = stall & ctlNe;
    doCommit = instValid & ~trapUd & ~trapNm & ~stall;
  end

  always_comb begin
    strobe = '0;
    strobe.wrSrc = SRC_GPR32;
    if (doCommit && isEmpty) strobe.tagAllEmpty = 1'b1;
    if (doCommit && isSimd) begin
      strobe.tagAllValid = 1'b1;
      case (opByte)
        OP_LD32: begin
          strobe.wrEn  = 1'b1;
          strobe.wrIdx = regA;
          strobe.wrSrc = SRC_GPR32;
        end
        OP_ST32: begin
          strobe.rdEn  = 1'b1;
          strobe.rdLow = 1'b1;
          strobe.rdIdx = regA;
        end
        OP_LD64: begin
          strobe.wrEn  = 1'b1;
          strobe.wrIdx = regA;
          strobe.rdIdx = regB;
          strobe.wrSrc = bIsMem ? SRC_MEM64 : SRC_REG;
        end
        OP_ST64: begin
          strobe.rdIdx = regA;
          if (bIsMem) begin
            strobe.rdEn = 1'b1;
          end else begin
            strobe.wrEn  = 1'b1;
            strobe.wrIdx = regB;
            strobe.wrSrc = SRC_REG;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit      <= 1'b0;
      faultValid  <= 1'b0;
      faultVector <= '0;
      ferr        <= 1'b0;
    end else begin
      commit     <= doCommit;
      faultValid <= trapUd | trapNm | trapMf;
      ferr       <= stall;
      if (trapUd)      faultVector <= VEC_UD;
      else if (trapNm) faultVector <= VEC_NM;
      else if (trapMf) faultVector <= VEC_MF;
      else             faultVector <= '0;
    end
  end

  a_r12_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(commit && faultValid));
  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> (!commit && !faultValid && !ferr));
  a_r4_ud_wins: assert property (@(posedge clk) disable iff (rst)
    (instValid && (instClass == 2'd1 || instClass == 2'd2) && (ctlEm || lockPfx))
    |=> (faultValid && faultVector == 8'd6));
  a_r5_fp_ts: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 2'd3 && ctlTs) |=> (faultValid && faultVector == 8'd7));
  a_r6_mf_has_ferr: assert property (@(posedge clk) disable iff (rst)
    (faultValid && faultVector == 8'd16) |-> ferr);
endmodule

// File: rtl/simd_fp_datapath.sv
module simd_fp_datapath
  import simd_fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [HALF_W-1:0] gprIn,
  input  logic [REG_W-1:0]  memIn,
  output logic [TAG_W-1:0]  tagWord,
  output logic [REG_W-1:0]  dataOut,
  output logic              dataOutValid
);
  logic [REG_W-1:0] regFile [NUM_REGS];
  logic [REG_W-1:0] rdVal;
  logic [REG_W-1:0] wrData;

  always_comb begin
    rdVal = regFile[strobe.rdIdx];
    case (strobe.wrSrc)
      SRC_MEM64: wrData = memIn;
      SRC_REG:   wrData = rdVal;
      default:   wrData = {{HALF_W{1'b0}}, gprIn};
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regFile[g] <= '0;
      else if (strobe.wrEn && strobe.wrIdx == IDX_W'(g)) regFile[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     tagWord <= '1;
    else if (strobe.tagAllEmpty) tagWord <= '1;
    else if (strobe.tagAllValid) tagWord <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut      <= '0;
      dataOutValid <= 1'b0;
    end else begin
      dataOutValid <= strobe.rdEn;
      if (strobe.rdEn)
        dataOut <= strobe.rdLow ? {{HALF_W{1'b0}}, rdVal[HALF_W-1:0]} : rdVal;
    end
  end

  a_r7_upper_cleared: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn && strobe.wrSrc == SRC_GPR32)
    |=> regFile[$past(strobe.wrIdx)][REG_W-1:HALF_W] == '0);
  a_r8_low_read_zext: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.rdLow) |=> dataOut[REG_W-1:HALF_W] == '0);
endmodule

// File: rtl/simd_fp_state_tracker.sv
module simd_fp_state_tracker
  import simd_fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [1:0]        instClass,
  input  logic [7:0]        opByte,
  input  logic              lockPfx,
  input  logic              ctlEm,
  input  logic              ctlTs,
  input  logic              ctlNe,
  input  logic              fpExcPend,
  input  logic [IDX_W-1:0]  regA,
  input  logic [IDX_W-1:0]  regB,
  input  logic              bIsMem,
  input  logic [HALF_W-1:0] gprIn,
  input  logic [REG_W-1:0]  memIn,
  output logic              commit,
  output logic              faultValid,
  output logic [7:0]        faultVector,
  output logic              ferr,
  output logic [TAG_W-1:0]  tagWord,
  output logic [REG_W-1:0]  dataOut,
  output logic              dataOutValid
);
  dpStrobe_t strobe;

  simd_fp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .opByte(opByte), .lockPfx(lockPfx), .ctlEm(ctlEm), .ctlTs(ctlTs),
    .ctlNe(ctlNe), .fpExcPend(fpExcPend), .regA(regA), .regB(regB),
    .bIsMem(bIsMem), .strobe(strobe), .commit(commit),
    .faultValid(faultValid), .faultVector(faultVector), .ferr(ferr)
  );

  simd_fp_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .gprIn(gprIn), .memIn(memIn),
    .tagWord(tagWord), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  a_r2_simd_tags_valid: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 2'd1 && !ctlEm && !lockPfx && !ctlTs && !fpExcPend)
    |=> (commit && tagWord == '0));
  a_r3_empty_tags: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 2'd2 && !ctlEm && !lockPfx && !ctlTs && !fpExcPend)
    |=> (commit && tagWord == '1));
  a_r4_fault_keeps_tags: assert property (@(posedge clk) disable iff (rst)
    faultValid |-> $stable(tagWord));
  a_r11_other_keeps_tags: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == 2'd0) |=> (commit && $stable(tagWord)));
endmodule

// File: tb/simd_fp_state_tracker_bench.sv
module simd_fp_state_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [1:0] instClass = '0;
  logic [7:0] opByte = '0;
  logic lockPfx = 1'b0, ctlEm = 1'b0, ctlTs = 1'b0, ctlNe = 1'b0, fpExcPend = 1'b0;
  logic [2:0] regA = '0, regB = '0;
  logic bIsMem = 1'b0;
  logic [31:0] gprIn = '0;
  logic [63:0] memIn = '0;
  logic commit, faultValid, ferr, dataOutValid;
  logic [7:0] faultVector;
  logic [15:0] tagWord;
  logic [63:0] dataOut;

  int nChecks = 0;
  int nFails = 0;
  logic [63:0] mReg [8];
  logic [15:0] mTag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simd_fp_state_tracker u_simd_fp_state_tracker (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .opByte(opByte), .lockPfx(lockPfx), .ctlEm(ctlEm), .ctlTs(ctlTs),
    .ctlNe(ctlNe), .fpExcPend(fpExcPend), .regA(regA), .regB(regB),
    .bIsMem(bIsMem), .gprIn(gprIn), .memIn(memIn), .commit(commit),
    .faultValid(faultValid), .faultVector(faultVector), .ferr(ferr),
    .tagWord(tagWord), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Drive one strobe at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic runOp(input logic [1:0] cls, input logic [7:0] op, input logic lk,
                       input logic em, input logic ts, input logic ne, input logic pend,
                       input logic [2:0] a, input logic [2:0] b, input logic bm,
                       input logic [31:0] g, input logic [63:0] m, input string reqIn);
    logic simdLike, ud, nm, stl, cm, eFault, eDv;
    logic [7:0] eVec;
    logic [63:0] eDo;
    string req;
    simdLike = (cls == 2'd1) || (cls == 2'd2);
    ud   = simdLike && (em || lk);
    nm   = !ud && (simdLike || cls == 2'd3) && ts;
    stl  = !ud && !nm && simdLike && pend;
    cm   = !ud && !nm && !stl;
    eFault = ud || nm || (stl && ne);
    eVec = ud ? 8'd6 : nm ? 8'd7 : 8'd16;
    eDv = 1'b0;
    eDo = '0;
    req = reqIn;
    if (req == "") req = ud ? "R4" : nm ? "R5" : stl ? "R6" :
                         (cls == 2'd0 || cls == 2'd3) ? "R11" : (cls == 2'd2) ? "R3" : "R2";
    if (cm && cls == 2'd2) mTag = 16'hFFFF;
    if (cm && cls == 2'd1) begin
      mTag = 16'h0000;
      case (op)
        8'h6E: mReg[a] = {32'h0, g};
        8'h7E: begin eDv = 1'b1; eDo = {32'h0, mReg[a][31:0]}; end
        8'h6F: mReg[a] = bm ? m : mReg[b];
        8'h7F: if (bm) begin eDv = 1'b1; eDo = mReg[a]; end else mReg[b] = mReg[a];
        default: ;
      endcase
    end
    instValid = 1'b1; instClass = cls; opByte = op; lockPfx = lk; ctlEm = em;
    ctlTs = ts; ctlNe = ne; fpExcPend = pend; regA = a; regB = b; bIsMem = bm;
    gprIn = g; memIn = m;
    @(negedge clk);
    instValid = 1'b0;
    check(req, "commit", 64'(commit), 64'(cm));
    check(req, "faultValid", 64'(faultValid), 64'(eFault));
    if (eFault) check(req, "faultVector", 64'(faultVector), 64'(eVec));
    check(req, "ferr", 64'(ferr), 64'(stl));
    check(req, "tagWord", 64'(tagWord), 64'(mTag));
    check(req, "dataOutValid", 64'(dataOutValid), 64'(eDv));
    if (eDv) check(req, "dataOut", dataOut, eDo);
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 8; i++)
      runOp(2'd1, 8'h7F, 0, 0, 0, 0, 0, 3'(i), 3'd0, 1'b1, 32'h0, 64'h0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    mTag = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "tagWord", 64'(tagWord), 64'hFFFF);
    check("R1", "commit", 64'(commit), 64'h0);
    check("R1", "faultValid", 64'(faultValid), 64'h0);
    check("R1", "dataOutValid", 64'(dataOutValid), 64'h0);
    readAll("R1");
    // R9: 64-bit loads from memory, then register to register
    for (int i = 0; i < 8; i++)
      runOp(2'd1, 8'h6F, 0, 0, 0, 0, 0, 3'(i), 3'd0, 1'b1, 32'h0,
            {32'(i) * 32'h9E3779B1, ~(32'(i) * 32'h85EBCA6B)}, "R9");
    runOp(2'd1, 8'h6F, 0, 0, 0, 0, 0, 3'd0, 3'd5, 1'b0, 32'h0, 64'hDEAD, "R9");
    readAll("R9");
    // R8: 32-bit reads of registers with non-zero upper halves
    for (int i = 0; i < 8; i++)
      runOp(2'd1, 8'h7E, 0, 0, 0, 0, 0, 3'(i), 3'd0, 1'b0, 32'h0, 64'h0, "R8");
    // R3: empty-state after valid tags
    runOp(2'd2, 8'h77, 0, 0, 0, 0, 0, 3'd0, 3'd0, 1'b0, 32'h0, 64'h0, "R3");
    // R7: 32-bit writes clear the upper half
    for (int i = 0; i < 8; i += 2)
      runOp(2'd1, 8'h6E, 0, 0, 0, 0, 0, 3'(i), 3'd0, 1'b0, 32'hA5A50000 + 32'(i), 64'h0, "R7");
    readAll("R7");
    // R10: register to register 64-bit store
    runOp(2'd1, 8'h7F, 0, 0, 0, 0, 0, 3'd1, 3'd6, 1'b0, 32'h0, 64'h0, "R10");
    runOp(2'd1, 8'h7F, 0, 0, 0, 0, 0, 3'd6, 3'd0, 1'b1, 32'h0, 64'h0, "R10");
    // R2: arithmetic-style SIMD op after an empty-state op
    runOp(2'd2, 8'h77, 0, 0, 0, 0, 0, 3'd0, 3'd0, 1'b0, 32'h0, 64'h0, "R3");
    runOp(2'd1, 8'hFC, 0, 0, 0, 0, 0, 3'd2, 3'd3, 1'b0, 32'h0, 64'h0, "R2");
    // R12: idle cycle produces nothing
    @(negedge clk);
    check("R12", "commit idle", 64'(commit), 64'h0);
    check("R12", "faultValid idle", 64'(faultValid), 64'h0);
    check("R12", "dataOutValid idle", 64'(dataOutValid), 64'h0);
    // R4 R5 R6 R11: sweep every class with every control combination
    for (int c = 0; c < 128; c++) begin
      logic [7:0] op;
      case (c % 5)
        0: op = 8'h6E;
        1: op = 8'h7E;
        2: op = 8'h6F;
        3: op = 8'h7F;
        default: op = 8'hDB;
      endcase
      if (c % 16 == 7) runOp(2'd2, 8'h77, 0, 0, 0, 0, 0, 3'd0, 3'd0, 1'b0, 32'h0, 64'h0, "R3");
      runOp(c[6:5], op, c[4], c[0], c[1], c[2], c[3], 3'(c), 3'(c * 3), c[2] ^ c[4],
            32'hC0DE0000 + 32'(c), {32'hF00D0000 + 32'(c), 32'(c)}, "");
      if (c % 16 == 15) readAll("R11");
    end
    finishRun();
  end
endmodule